// File: doc/BRIEF.md
# Per-Hart Software Interrupt Bank

This block gives software a way to raise an interrupt on any hart of a multi-hart system. It sits on a simple request bus and provides one 32-bit word register per hart, laid out back to back from the block base. Each hart has one interrupt output. Writing a one to a hart's word raises that hart's interrupt.

A static parameter, `SET_ONLY`, picks one of two variants at build time. With `SET_ONLY = 0` (machine variant) each word is an ordinary read/write pending bit: writing zero lowers the interrupt, a read returns the bit, and reset clears every bit. With `SET_ONLY = 1` (supervisor variant) each word is a set port only. It always reads zero and ignores writes of zero. The pending bit is dropped by the receiving hart through its own clear input, and reset leaves the bits alone.

Reads respond exactly one cycle after the request. Interrupt outputs come straight from flops.

Top module: `swint_bank`

## Requirements
- R1: A request selects hart `h` only when all three hold: the offset `req_addr` equals `4*h` (word aligned), `h < NUM_HARTS`, and `req_size` is 2'b10 (4 bytes). The size codes are 0 = byte, 1 = half, 2 = word, 3 = double.
- R2: A write that selects hart `h` with `req_wdata[0] = 1` sets `irq[h]` at the next clock edge. Bits 31 to 1 of the write data have no effect.
- R3: In the machine variant, a write that selects hart `h` with `req_wdata[0] = 0` clears `irq[h]` at the next clock edge.
- R4: In the supervisor variant, a write of `req_wdata[0] = 0` leaves `irq[h]` unchanged.
- R5: In the supervisor variant, `irq_clr[h]` clears `irq[h]` at the next edge. A bus set to the same hart in the same cycle wins over the clear.
- R6: In the machine variant, `irq_clr` has no effect.
- R7: A read raises `rsp_valid` for one cycle, one cycle after the request. In the machine variant, `rsp_rdata[0]` is the selected hart's pending bit and bits 31 to 1 are zero.
- R8: In the supervisor variant, every read returns zero.
- R9: A request that is misaligned, beyond the hart count, or not 4 bytes wide reads zero and changes no pending bit.
- R10: Synchronous reset clears `rsp_valid`. In the machine variant it clears every pending bit. In the supervisor variant it leaves the pending bits as they are.
- R11: An access to one hart leaves the pending bits of all other harts unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte offset from block base |
| req_size | input | 2 | Access width code (2 = 4 bytes) |
| req_wdata | input | DATA_W | Write data; only bit 0 matters |
| irq_clr | input | NUM_HARTS | Per-hart pending clear (supervisor variant) |
| rsp_valid | output | 1 | Read data valid, one cycle after a read |
| rsp_rdata | output | DATA_W | Read data |
| irq | output | NUM_HARTS | Per-hart software interrupt |

## Verification
The assertions assume each request is a single-cycle strobe with all request fields stable in that cycle. They also assume that `irq_clr` is only meaningful in the supervisor variant, and that in that variant it is held high through the first reset so the pending bits start from a known value. The bench drives each request for exactly one cycle at the falling edge and then drops `req_valid`. It holds `irq_clr` high during the initial reset and releases it afterwards. It also pulses `irq_clr` on its own and together with a set, to reach the clear-versus-set case.

// File: rtl/swint_pkg.sv
package swint_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'd0,
    SZ_HALF  = 2'd1,
    SZ_WORD  = 2'd2,
    SZ_DWORD = 2'd3
  } acc_size_e;

  localparam int unsigned WORD_SHIFT = 2;

endpackage

// File: rtl/swint_decode.sv
module swint_decode #(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [1:0]           size,
  output logic                 hit,
  output logic [NUM_HARTS-1:0] sel
);
  import swint_pkg::*;

  localparam int unsigned WI_W = ADDR_W - WORD_SHIFT;

  logic [WI_W-1:0] word_idx;
  logic            aligned;
  logic            in_range;
  logic            size_ok;

  assign word_idx = addr[ADDR_W-1:WORD_SHIFT];
  assign aligned  = (addr[WORD_SHIFT-1:0] == '0);
  assign in_range = (word_idx < WI_W'(NUM_HARTS));
  assign size_ok  = (acc_size_e'(size) == SZ_WORD);
  assign hit      = aligned && in_range && size_ok;

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_sel
    assign sel[h] = hit && (word_idx == WI_W'(h));
  end

  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sel));

  // R1
  hit_one_sel_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> ($countones(sel) == 1));

endmodule

// File: rtl/swint_cell.sv
module swint_cell #(
  parameter bit SET_ONLY = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_sel,
  input  logic wbit,
  input  logic clr,
  output logic pend
);

  if (SET_ONLY) begin : g_set_only
    always_ff @(posedge clk) begin
      if (wr_sel && wbit) pend <= 1'b1;
      else if (clr)       pend <= 1'b0;
    end

    // R4
    zero_write_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_sel && !wbit && !clr) |=> $stable(pend));

    // R5
    clear_drop_chk: assert property (@(posedge clk) disable iff (rst)
      (clr && !(wr_sel && wbit)) |=> !pend);
  end else begin : g_rw
    logic unused_clr;
    assign unused_clr = clr;

    always_ff @(posedge clk) begin
      if (rst)         pend <= 1'b0;
      else if (wr_sel) pend <= wbit;
    end

    // R10
    reset_clear_chk: assert property (@(posedge clk)
      rst |=> !pend);

    // R3
    zero_write_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_sel && !wbit) |=> !pend);

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !wr_sel |=> $stable(pend));
  end

  // R2
  set_takes_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_sel && wbit) |=> pend);

endmodule

// File: rtl/swint_readback.sv
module swint_readback #(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned DATA_W    = 32,
  parameter bit          SET_ONLY  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_req,
  input  logic [NUM_HARTS-1:0] sel,
  input  logic [NUM_HARTS-1:0] pend,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata
);

  logic rd_bit;
  assign rd_bit = SET_ONLY ? 1'b0 : |(pend & sel);

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rd_req;
      rsp_rdata <= rd_req ? {{(DATA_W-1){1'b0}}, rd_bit} : '0;
    end
  end

  // R7
  read_latency_chk: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rsp_valid);

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> (rsp_rdata[DATA_W-1:1] == '0));

  // R10
  rsp_reset_chk: assert property (@(posedge clk)
    rst |=> !rsp_valid);

endmodule

// File: rtl/swint_bank.sv
module swint_bank #(
  parameter int unsigned NUM_HARTS = 4,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 32,
  parameter bit          SET_ONLY  = 1'b0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [1:0]           req_size,
  input  logic [DATA_W-1:0]    req_wdata,
  input  logic [NUM_HARTS-1:0] irq_clr,
  output logic                 rsp_valid,
  output logic [DATA_W-1:0]    rsp_rdata,
  output logic [NUM_HARTS-1:0] irq
);

  logic                 hit;
  logic [NUM_HARTS-1:0] sel;
  logic [NUM_HARTS-1:0] wr_sel;
  logic [NUM_HARTS-1:0] pend;
  logic                 rd_req;
  logic                 unused_wdata;

  assign unused_wdata = ^req_wdata[DATA_W-1:1];
  assign rd_req       = req_valid && !req_write;

  swint_decode #(
    .NUM_HARTS (NUM_HARTS),
    .ADDR_W    (ADDR_W)
  ) u_decode (
    .clk  (clk),
    .rst  (rst),
    .addr (req_addr),
    .size (req_size),
    .hit  (hit),
    .sel  (sel)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    assign wr_sel[h] = req_valid && req_write && sel[h];

    swint_cell #(
      .SET_ONLY (SET_ONLY)
    ) u_cell (
      .clk    (clk),
      .rst    (rst),
      .wr_sel (wr_sel[h]),
      .wbit   (req_wdata[0]),
      .clr    (irq_clr[h]),
      .pend   (pend[h])
    );
  end

  swint_readback #(
    .NUM_HARTS (NUM_HARTS),
    .DATA_W    (DATA_W),
    .SET_ONLY  (SET_ONLY)
  ) u_readback (
    .clk       (clk),
    .rst       (rst),
    .rd_req    (rd_req),
    .sel       (sel),
    .pend      (pend),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign irq = pend;

  // R9
  miss_no_change_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !hit && (irq_clr == '0)) |=> $stable(irq));

  // R11
  other_harts_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_clr == '0) |=> (((irq ^ $past(irq)) & ~$past(sel)) == '0));

endmodule

// File: tb/test_swint_bank.sv
module test_swint_bank;

  localparam int unsigned PERIOD = 10;
  localparam int unsigned NH     = 4;
  localparam int unsigned AW     = 8;
  localparam int unsigned DW     = 32;

  typedef struct packed {
    logic          wr;
    logic [AW-1:0] addr;
    logic [1:0]    sz;
    logic [DW-1:0] wd;
    logic [NH-1:0] eirq;
    logic [DW-1:0] erd;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 8'h04, 2'd2, 32'h0000_0001, 4'b0010, 32'h0},  // R2 set hart1
    '{1'b1, 8'h0C, 2'd2, 32'hFFFF_FFFF, 4'b1010, 32'h0},  // R2 set hart3
    '{1'b0, 8'h04, 2'd2, 32'h0,         4'b1010, 32'h1},  // R7 read hart1
    '{1'b0, 8'h08, 2'd2, 32'h0,         4'b1010, 32'h0},  // R7 read hart2
    '{1'b1, 8'h04, 2'd2, 32'hFFFF_FFFE, 4'b1000, 32'h0},  // R3 clear hart1
    '{1'b1, 8'h10, 2'd2, 32'h0000_0001, 4'b1000, 32'h0},  // R9 out of range
    '{1'b1, 8'h01, 2'd2, 32'h0000_0001, 4'b1000, 32'h0},  // R9 misaligned
    '{1'b1, 8'h00, 2'd0, 32'h0000_0001, 4'b1000, 32'h0},  // R9 byte size
    '{1'b1, 8'h00, 2'd2, 32'h0000_0001, 4'b1001, 32'h0},  // R1 hart0
    '{1'b0, 8'h0C, 2'd2, 32'h0,         4'b1001, 32'h1},  // R7 read hart3
    '{1'b0, 8'h0E, 2'd2, 32'h0,         4'b1001, 32'h0},  // R9 misaligned rd
    '{1'b0, 8'h10, 2'd2, 32'h0,         4'b1001, 32'h0},  // R9 range rd
    '{1'b0, 8'h00, 2'd3, 32'h0,         4'b1001, 32'h0},  // R9 dword rd
    '{1'b1, 8'h0C, 2'd2, 32'h0,         4'b0001, 32'h0},  // R3 R11 clear hart3
    '{1'b0, 8'h00, 2'd2, 32'h0,         4'b0001, 32'h1}   // R7 read hart0
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          vld_m = 1'b0, vld_s = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0]    req_size = 2'd2;
  logic [DW-1:0] req_wdata = '0;
  logic [NH-1:0] clr_m = '0, clr_s = '1;
  logic          rv_m, rv_s;
  logic [DW-1:0] rd_m, rd_s;
  logic [NH-1:0] irq_m, irq_s;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  swint_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .DATA_W(DW), .SET_ONLY(1'b0)) i_swint_bank (
    .clk(clk), .rst(rst), .req_valid(vld_m), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .irq_clr(clr_m), .rsp_valid(rv_m), .rsp_rdata(rd_m), .irq(irq_m));

  swint_bank #(.NUM_HARTS(NH), .ADDR_W(AW), .DATA_W(DW), .SET_ONLY(1'b1)) i_swint_bank_so (
    .clk(clk), .rst(rst), .req_valid(vld_s), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .irq_clr(clr_s), .rsp_valid(rv_s), .rsp_rdata(rd_s), .irq(irq_s));

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic access(input bit to_s, input logic wr, input logic [AW-1:0] a,
                        input logic [1:0] sz, input logic [DW-1:0] wd);
    @(negedge clk);
    req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
    if (to_s) vld_s = 1'b1; else vld_m = 1'b1;
    @(negedge clk);
    vld_m = 1'b0; vld_s = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    clr_s = '0;
    // R10 reset state
    check("R10 irq_m", DW'(irq_m), '0);
    check("R10 rv_m", DW'(rv_m), '0);
    check("R10 irq_s", DW'(irq_s), '0);

    for (int i = 0; i < NV; i++) begin
      access(1'b0, VECS[i].wr, VECS[i].addr, VECS[i].sz, VECS[i].wd);
      check($sformatf("vec%0d irq", i), DW'(irq_m), DW'(VECS[i].eirq));
      check($sformatf("vec%0d rsp_valid", i), DW'(rv_m), DW'(!VECS[i].wr));
      check($sformatf("vec%0d rdata", i), rd_m, VECS[i].erd);
    end

    // R6 clear input ignored in machine variant
    @(negedge clk); clr_m = '1;
    @(negedge clk); clr_m = '0;
    check("R6 clr ignored", DW'(irq_m), 32'h1);

    // R2 set-only variant
    access(1'b1, 1'b1, 8'h08, 2'd2, 32'h1);
    check("R2 so set", DW'(irq_s), 32'h4);
    // R8 read zero
    access(1'b1, 1'b0, 8'h08, 2'd2, 32'h0);
    check("R8 so valid", DW'(rv_s), 32'h1);
    check("R8 so rdata", rd_s, 32'h0);
    // R4 write zero ignored
    access(1'b1, 1'b1, 8'h08, 2'd2, 32'h0);
    check("R4 so zero write", DW'(irq_s), 32'h4);
    // R5 clear input
    @(negedge clk); clr_s = 4'b0100;
    @(negedge clk); clr_s = '0;
    check("R5 so clear", DW'(irq_s), 32'h0);
    // R5 set wins over clear
    @(negedge clk);
    req_write = 1'b1; req_addr = 8'h04; req_size = 2'd2; req_wdata = 32'h1;
    vld_s = 1'b1; clr_s = 4'b0010;
    @(negedge clk);
    vld_s = 1'b0; clr_s = '0;
    check("R5 set wins", DW'(irq_s), 32'h2);

    // R10 second reset
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check("R10 irq_m cleared", DW'(irq_m), '0);
    check("R10 irq_s kept", DW'(irq_s), 32'h2);
    check("R10 rv_m", DW'(rv_m), '0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule